// File: doc/BRIEF.md
# Interrupt Enable and Mode Control

This block holds the interrupt-control state of an 8-bit processor core: two interrupt-enable flags, a two-bit interrupt mode and a halt flag. The fetch stage offers it one instruction byte per slot. The slot comes with a strobe and with a flag that marks the byte as the second byte of an extended-prefix opcode. The block recognises the enable, disable and halt opcodes and the mode-select opcodes. It updates its state and returns, one clock later, a report with the instruction's cycle count and whether the program counter steps forward.

While halted, the block answers every slot as a stalled no-operation. This report carries the normal short cycle count and no program counter step, and the slot's byte has no effect. A wake input, driven by the interrupt logic outside this block, ends the halt. It also produces the single program counter step that moves past the halt opcode. Interrupt acknowledge, vector fetch and non-maskable handling live elsewhere.

Top module: `irq_mode_ctrl`

## Requirements
- R1: A plain slot with byte 0xF3, not halted, clears both enable flags. It reports 4 cycles with a program counter step.
- R2: A plain slot with byte 0xFB, not halted, sets both enable flags. It reports 4 cycles with a step.
- R3: An extended slot with byte 0x46, 0x4E, 0x66 or 0x6E selects mode 0 (`imode` = 2'b00). It reports 8 cycles with a step.
- R4: An extended slot with byte 0x56 or 0x76 selects mode 1 (`imode` = 2'b01). Byte 0x5E or 0x7E selects mode 2 (`imode` = 2'b11). Each reports 8 cycles with a step. `imode` never holds 2'b10.
- R5: A plain slot with byte 0x76, not halted, sets `halted`. It reports 4 cycles with no step.
- R6: While halted and without wake, each slot reports 4 cycles with no step, whatever its byte. The enable flags and the mode stay unchanged.
- R7: Wake while halted clears `halted` and reports a step. The cycle count is 4 if a slot is offered in the same clock and 0 if not.
- R8: Wake while not halted has no effect: no report and no state change.
- R9: Any other byte, plain or extended, gives no report and leaves the state unchanged.
- R10: Reset clears both enable flags, the mode, `halted` and the report. Release of the asynchronous reset takes effect after two clock edges.
- R11: The report appears exactly one clock after its slot, and `rpt_vld` is low in any clock that had neither a slot nor a wake-while-halted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| slot_vld | input | 1 | Instruction slot strobe |
| slot_ext | input | 1 | Byte is the second byte of an extended-prefix opcode |
| slot_byte | input | 8 | Opcode byte |
| wake | input | 1 | Leave the halt state |
| ie1 | output | 1 | First interrupt-enable flag |
| ie2 | output | 1 | Second interrupt-enable flag |
| imode | output | 2 | Interrupt mode (00, 01, 11) |
| halted | output | 1 | Halt state |
| rpt_vld | output | 1 | Report valid |
| rpt_cyc | output | CYC_W | Reported cycle count |
| rpt_step | output | 1 | Program counter advances by one |

## Verification
The bench builds the block with its default parameters: a 4-bit cycle field, counts of 4 and 8, and two reset synchroniser stages. Because the opcode space is only 512 byte/extension pairs, the bench sweeps all of them from the running state. This reaches every aliased mode encoding, the collision between the plain halt byte and the extended mode-1 byte, and every ignored code. Halt is then probed with enable, disable and mode bytes, with wake alone and with wake together with a slot, and with reset applied over a non-zero state.

// File: rtl/icm_pkg.sv
package icm_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_DIS,
    OP_ENA,
    OP_HALT,
    OP_MODE
  } op_kind_e;

  typedef enum logic [1:0] {
    IMODE_0 = 2'b00,
    IMODE_1 = 2'b01,
    IMODE_2 = 2'b11
  } imode_e;

  localparam logic [7:0] BYTE_DIS  = 8'hF3;
  localparam logic [7:0] BYTE_ENA  = 8'hFB;
  localparam logic [7:0] BYTE_HALT = 8'h76;

endpackage

// File: rtl/icm_rst_sync.sv
module icm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("icm_rst_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/icm_decode.sv
module icm_decode
  import icm_pkg::*;
(
  input  logic       ext,
  input  logic [7:0] opc,
  output op_kind_e   kind,
  output imode_e     mode
);

  always_comb begin
    kind = OP_NONE;
    mode = IMODE_0;
    if (ext) begin
      // mode selects: 01 xxx 110, bit 5 is an alias bit, bits 4:3 pick the mode
      if (opc[7:6] == 2'b01 && opc[2:0] == 3'b110) begin
        kind = OP_MODE;
        case (opc[4:3])
          2'b10:   mode = IMODE_1;
          2'b11:   mode = IMODE_2;
          default: mode = IMODE_0;
        endcase
      end
    end else begin
      case (opc)
        BYTE_DIS:  kind = OP_DIS;
        BYTE_ENA:  kind = OP_ENA;
        BYTE_HALT: kind = OP_HALT;
        default:   kind = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/icm_state.sv
module icm_state
  import icm_pkg::*;
#(
  parameter int CYC_W     = 4,
  parameter int CYC_SHORT = 4,
  parameter int CYC_MODE  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_vld,
  input  op_kind_e         kind,
  input  imode_e           mode,
  input  logic             wake,
  output logic             ie1,
  output logic             ie2,
  output logic [1:0]       imode,
  output logic             halted,
  output logic             rpt_vld,
  output logic [CYC_W-1:0] rpt_cyc,
  output logic             rpt_step
);

  localparam logic [CYC_W-1:0] CYC_SHORT_V = CYC_W'(CYC_SHORT);
  localparam logic [CYC_W-1:0] CYC_MODE_V  = CYC_W'(CYC_MODE);

  logic             ie1_q, ie2_q, halt_q;
  logic [1:0]       imode_q;
  logic             ie1_d, ie2_d, halt_d;
  logic [1:0]       imode_d;
  logic             st_en;
  logic             rv_q, rv_d, rs_q, rs_d;
  logic [CYC_W-1:0] rc_q, rc_d;

  always_comb begin
    ie1_d   = ie1_q;
    ie2_d   = ie2_q;
    imode_d = imode_q;
    halt_d  = halt_q;
    rv_d    = 1'b0;
    rc_d    = '0;
    rs_d    = 1'b0;
    if (halt_q) begin
      if (wake) begin
        halt_d = 1'b0;
        rv_d   = 1'b1;
        rs_d   = 1'b1;
        rc_d   = slot_vld ? CYC_SHORT_V : '0;
      end else if (slot_vld) begin
        rv_d = 1'b1;
        rc_d = CYC_SHORT_V;
      end
    end else if (slot_vld) begin
      case (kind)
        OP_DIS: begin
          ie1_d = 1'b0; ie2_d = 1'b0;
          rv_d = 1'b1; rc_d = CYC_SHORT_V; rs_d = 1'b1;
        end
        OP_ENA: begin
          ie1_d = 1'b1; ie2_d = 1'b1;
          rv_d = 1'b1; rc_d = CYC_SHORT_V; rs_d = 1'b1;
        end
        OP_HALT: begin
          halt_d = 1'b1;
          rv_d = 1'b1; rc_d = CYC_SHORT_V;
        end
        OP_MODE: begin
          imode_d = mode;
          rv_d = 1'b1; rc_d = CYC_MODE_V; rs_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign st_en = slot_vld | (halt_q & wake);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie1_q   <= 1'b0;
      ie2_q   <= 1'b0;
      imode_q <= 2'b00;
      halt_q  <= 1'b0;
    end else if (st_en) begin
      ie1_q   <= ie1_d;
      ie2_q   <= ie2_d;
      imode_q <= imode_d;
      halt_q  <= halt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rc_q <= '0;
      rs_q <= 1'b0;
    end else begin
      rv_q <= rv_d;
      rc_q <= rc_d;
      rs_q <= rs_d;
    end
  end

  assign ie1      = ie1_q;
  assign ie2      = ie2_q;
  assign imode    = imode_q;
  assign halted   = halt_q;
  assign rpt_vld  = rv_q;
  assign rpt_cyc  = rc_q;
  assign rpt_step = rs_q;

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    imode_q != 2'b10); // R4

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q && !wake |=> $stable({ie1_q, ie2_q, imode_q}) && halt_q); // R6

endmodule

// File: rtl/irq_mode_ctrl.sv
module irq_mode_ctrl
  import icm_pkg::*;
#(
  parameter int CYC_W       = 4,
  parameter int CYC_SHORT   = 4,
  parameter int CYC_MODE    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             slot_vld,
  input  logic             slot_ext,
  input  logic [7:0]       slot_byte,
  input  logic             wake,
  output logic             ie1,
  output logic             ie2,
  output logic [1:0]       imode,
  output logic             halted,
  output logic             rpt_vld,
  output logic [CYC_W-1:0] rpt_cyc,
  output logic             rpt_step
);

  logic     rst_n;
  op_kind_e kind;
  imode_e   mode;

  icm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  icm_decode u_dec (
    .ext  (slot_ext),
    .opc  (slot_byte),
    .kind (kind),
    .mode (mode)
  );

  icm_state #(
    .CYC_W     (CYC_W),
    .CYC_SHORT (CYC_SHORT),
    .CYC_MODE  (CYC_MODE)
  ) u_st (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_vld (slot_vld),
    .kind     (kind),
    .mode     (mode),
    .wake     (wake),
    .ie1      (ie1),
    .ie2      (ie2),
    .imode    (imode),
    .halted   (halted),
    .rpt_vld  (rpt_vld),
    .rpt_cyc  (rpt_cyc),
    .rpt_step (rpt_step)
  );

  AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld && !slot_ext && slot_byte == 8'hF3 && !halted
    |=> !ie1 && !ie2 && rpt_step); // R1

  AST_ENA_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld && !slot_ext && slot_byte == 8'hFB && !halted
    |=> ie1 && ie2 && rpt_step); // R2

  AST_MODE2_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld && slot_ext && slot_byte == 8'h7E && !halted
    |=> imode == 2'b11 && rpt_cyc == CYC_W'(CYC_MODE)); // R4

  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld && !slot_ext && slot_byte == 8'h76 && !halted
    |=> halted && rpt_vld && !rpt_step); // R5

  AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    halted && wake |=> !halted && rpt_vld && rpt_step); // R7

  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !halted && !slot_vld |=> $stable({ie1, ie2, imode, halted}) && !rpt_vld); // R8

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_vld && !(halted && wake) |=> !rpt_vld); // R11

endmodule

// File: tb/irq_mode_ctrl_test.sv
module irq_mode_ctrl_test;

  logic       clk = 1'b0;
  logic       arst_n;
  logic       slot_vld, slot_ext, wake;
  logic [7:0] slot_byte;
  logic       ie1, ie2, halted, rpt_vld, rpt_step;
  logic [1:0] imode;
  logic [3:0] rpt_cyc;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic       m_ie, m_halt;
  logic [1:0] m_mode;

  always #10 clk = ~clk;

  irq_mode_ctrl uut (
    .clk(clk), .arst_n(arst_n), .slot_vld(slot_vld), .slot_ext(slot_ext),
    .slot_byte(slot_byte), .wake(wake), .ie1(ie1), .ie2(ie2), .imode(imode),
    .halted(halted), .rpt_vld(rpt_vld), .rpt_cyc(rpt_cyc), .rpt_step(rpt_step)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check(req, "ie1", int'(ie1), int'(m_ie));
    check(req, "ie2", int'(ie2), int'(m_ie));
    check(req, "imode", int'(imode), int'(m_mode));
    check(req, "halted", int'(halted), int'(m_halt));
  endtask

  // one clock: drive at negedge, sample at the next negedge
  task automatic step(input logic v, input logic e, input logic [7:0] b,
                      input logic w, input string req);
    logic xv, xs;
    int   xc;
    int   idx;
    xv = 0; xs = 0; xc = 0;
    if (m_halt) begin
      if (w) begin
        xv = 1; xs = 1; xc = v ? 4 : 0; m_halt = 0;
      end else if (v) begin
        xv = 1; xc = 4;
      end
    end else if (v) begin
      if (!e && b == 8'hF3)      begin m_ie = 0; xv = 1; xc = 4; xs = 1; end
      else if (!e && b == 8'hFB) begin m_ie = 1; xv = 1; xc = 4; xs = 1; end
      else if (!e && b == 8'h76) begin m_halt = 1; xv = 1; xc = 4; end
      else if (e && b[7:6] == 2'b01 && b[2:0] == 3'b110) begin
        idx = int'(b[4:3]);
        m_mode = (idx < 2) ? 2'b00 : ((idx == 2) ? 2'b01 : 2'b11);
        xv = 1; xc = 8; xs = 1;
      end
    end
    slot_vld = v; slot_ext = e; slot_byte = b; wake = w;
    @(negedge clk);
    check(req, "rpt_vld", int'(rpt_vld), int'(xv));
    if (xv) begin
      check(req, "rpt_cyc", int'(rpt_cyc), xc);
      check(req, "rpt_step", int'(rpt_step), int'(xs));
    end
    check_state(req);
    slot_vld = 0; slot_ext = 0; slot_byte = 8'h00; wake = 0;
  endtask

  task automatic do_reset();
    arst_n = 0;
    m_ie = 0; m_halt = 0; m_mode = 2'b00;
    @(negedge clk);
    check("R10", "rpt_vld in reset", int'(rpt_vld), 0);
    check_state("R10");
    arst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    slot_vld = 0; slot_ext = 0; slot_byte = 8'h00; wake = 0;
    do_reset();
    check_state("R10");

    step(1, 0, 8'hFB, 0, "R2");
    step(1, 0, 8'hF3, 0, "R1");
    step(0, 0, 8'h00, 1, "R8");
    step(0, 0, 8'h00, 0, "R11");

    // full sweep of byte and extension flag
    for (int e = 0; e < 2; e++) begin
      for (int b = 0; b < 256; b++) begin
        step(1, e[0], b[7:0], 0, "R9 sweep R3 R4");
        if (m_halt) step(0, 0, 8'h00, 1, "R7");
      end
    end

    // halted: bytes must not act
    step(1, 1, 8'h7E, 0, "R4");
    step(1, 0, 8'hFB, 0, "R2");
    step(1, 0, 8'h76, 0, "R5");
    step(1, 0, 8'hF3, 0, "R6");
    step(1, 1, 8'h46, 0, "R6");
    step(0, 0, 8'h00, 0, "R6 idle");
    step(1, 0, 8'h76, 0, "R6");
    step(1, 0, 8'hF3, 1, "R7 wake with slot");
    step(1, 0, 8'hF3, 0, "R1");
    step(1, 1, 8'h56, 0, "R4");
    step(1, 1, 8'h66, 0, "R3");
    step(1, 0, 8'h76, 0, "R5");
    step(0, 0, 8'h00, 1, "R7 wake alone");
    step(0, 0, 8'h00, 0, "R11");

    // reset over a non-zero state
    step(1, 0, 8'hFB, 0, "R2");
    step(1, 1, 8'h5E, 0, "R4");
    step(1, 0, 8'h76, 0, "R5");
    do_reset();
    check_state("R10");
    step(0, 0, 8'h00, 1, "R8 after reset");

    finish_run();
  end

endmodule